// File: doc/BRIEF.md
# LED Sink Driver Fault Scan Sequencer

This block sits on the host side of a serial constant-current LED sink driver. It runs one full open/short diagnostic pass on a 16-output driver. A one-cycle `start` pulse launches the pass. The block first plays the key pattern that moves the driver into its test mode. It then shifts an all-ones word so that every output is switched on during the test, and latches that word into the driver. Next it holds the active-low output enable low for a timed sensing window, then drives it high again. It clocks the driver's sixteen fault flags back in over the serial return line, and plays the key pattern that returns the driver to normal operation.

When the pass is over, the block presents the captured fault word and raises `done` for one cycle. The serial clock toward the driver runs at half the system clock. Each pulse is one system cycle low followed by one high. Data, latch and enable lines only move when the serial clock falls or while it rests low, so the driver always sees settled levels at its rising edge. A `start` that arrives while a pass is running has no effect.

Top module: `fault_scan_sequencer`

## Requirements
- R1: While reset is held and afterwards until a pass starts: `drv_clk`=0, `drv_oe_n`=1, `drv_le`=0, `drv_sdi`=0, `done`=0, `result`=0.
- R2: Every `drv_clk` pulse is one system cycle low then one system cycle high. `drv_sdi`, `drv_le` and `drv_oe_n` never change on the cycle in which `drv_clk` rises.
- R3: A pass opens with five clock pulses. The `drv_oe_n` levels are 1,0,1,1,1 and the `drv_le` levels are 0,0,0,1,0, listed from the first pulse to the fifth.
- R4: Sixteen clock pulses follow with `drv_sdi`=1, `drv_oe_n`=1 and `drv_le`=0, so the driver's latch holds all ones.
- R5: `drv_le` is then high for exactly two system cycles with `drv_clk` held low.
- R6: `drv_oe_n` is then low for exactly DET_CYCLES system cycles with `drv_clk` low, then returns high. The default of 100 is 1 µs at 100 MHz.
- R7: Sixteen read pulses follow. `drv_sdo` is sampled on the system edge at which `drv_clk` rises. The first sample lands in `result[15]` and the last in `result[0]`, and a 1 bit is a reported fault.
- R8: Five closing clock pulses follow, with `drv_oe_n` at 1,0,1,1,1 and `drv_le` low on all five. After them the driver is back in normal mode.
- R9: `done` is high for one system cycle. That cycle begins 2·(2·5 + 2·16 + 1) + DET_CYCLES = 86 + DET_CYCLES system edges after the edge that samples `start`. `result` changes only on the edge that raises `done`.
- R10: A `start` sampled while a pass is in progress, including its `done` cycle, does not restart the pass or cause a second `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to run a diagnostic pass |
| drv_sdo | input | 1 | Serial return line from the driver |
| drv_clk | output | 1 | Serial shift clock to the driver |
| drv_sdi | output | 1 | Serial data to the driver |
| drv_le | output | 1 | Latch strobe to the driver |
| drv_oe_n | output | 1 | Active-low output enable to the driver |
| result | output | 16 | Fault word from the last pass, bit 15 = output 15 |
| done | output | 1 | One-cycle pulse marking a finished pass |

## Verification
The bench runs each pass against a behavioural driver model. The model decodes the key patterns from the levels seen at each rising serial clock. It returns the injected fault word only if it really is in test mode, holds all ones in its latch, and saw a full-length sensing window. Otherwise it returns the complement, so any broken step shows up as a wrong result. The fault words cover all-clear, all-faulty, single faults at either end and alternating patterns, which separate a reversed or shifted readback order from a correct one. Seeded random words then fill in the rest. Two passes receive a second `start` in mid-pass and in the final cycles; these show whether the request restarts the pass or produces a second `done`.

// File: rtl/fds_pkg.sv
package fds_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ENTRY, PH_LOAD, PH_LATCH, PH_WINDOW, PH_READ, PH_EXIT, PH_DONE
  } phase_t;

  localparam int KEY_LEN = 5;

  // enable level (active low) for key pulse idx, shared by both keys
  function automatic logic key_oe_n(input int idx);
    case (idx)
      1:       return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  // latch level for key pulse idx of the entry key; exit key keeps it low
  function automatic logic key_le_entry(input int idx);
    return (idx == 3);
  endfunction

  // number of clock slots a phase spends
  function automatic int phase_slots(input phase_t ph, input int bits);
    case (ph)
      PH_ENTRY, PH_EXIT: return KEY_LEN;
      PH_LOAD, PH_READ:  return bits;
      PH_LATCH:          return 1;
      default:           return 0;
    endcase
  endfunction

  // phases in which the serial clock actually toggles
  function automatic logic phase_pulses(input phase_t ph);
    return (ph == PH_ENTRY) || (ph == PH_LOAD) || (ph == PH_READ) || (ph == PH_EXIT);
  endfunction

  // system edges from the start-sampling edge to the done cycle
  function automatic int pass_length(input int bits, input int det);
    return 2 * (2 * KEY_LEN + 2 * bits + 1) + det;
  endfunction

endpackage

// File: rtl/fds_slot_pacer.sv
module fds_slot_pacer #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             run,
  output logic             half,
  output logic [IDX_W-1:0] idx,
  output logic             slot_end
);
  always_ff @(posedge clk) begin
    if (rst || restart) begin
      half <= 1'b0;
      idx  <= '0;
    end else if (run) begin
      half <= ~half;
      if (half) idx <= idx + 1'b1;
    end
  end

  assign slot_end = run && half;

  a_r2_half_alternates: assert property (@(posedge clk) disable iff (rst)
    (run && !restart && !half) |=> half);
endmodule

// File: rtl/fds_window_timer.sv
module fds_window_timer #(
  parameter int DET_CYCLES = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  output logic expire
);
  localparam int CNT_W = $clog2(DET_CYCLES + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !active) cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  assign expire = active && (cnt == CNT_W'(DET_CYCLES - 1));

  a_r6_timer_bound: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt < CNT_W'(DET_CYCLES)));
endmodule

// File: rtl/fds_readback.sv
module fds_readback #(
  parameter int BITS = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  logic            bit_in,
  output logic [BITS-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst)       word <= '0;
    else if (take) word <= {word[BITS-2:0], bit_in};
  end
endmodule

// File: rtl/fault_scan_sequencer.sv
module fault_scan_sequencer #(
  parameter int BITS       = 16,
  parameter int DET_CYCLES = 100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            drv_sdo,
  output logic            drv_clk,
  output logic            drv_sdi,
  output logic            drv_le,
  output logic            drv_oe_n,
  output logic [BITS-1:0] result,
  output logic            done
);
  import fds_pkg::*;

  localparam int IDX_W = $clog2(BITS + 1);

  phase_t           phase_q, phase_d;
  logic             half, slot_end, slot_last, pacer_run, restart;
  logic             win_active, win_expire, take;
  logic [IDX_W-1:0] idx;
  logic [BITS-1:0]  captured;

  assign pacer_run  = phase_pulses(phase_q) || (phase_q == PH_LATCH);
  assign slot_last  = slot_end && (idx == IDX_W'(phase_slots(phase_q, BITS) - 1));
  assign win_active = (phase_q == PH_WINDOW);
  assign take       = (phase_q == PH_READ) && !half;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE:   if (start)      phase_d = PH_ENTRY;
      PH_ENTRY:  if (slot_last)  phase_d = PH_LOAD;
      PH_LOAD:   if (slot_last)  phase_d = PH_LATCH;
      PH_LATCH:  if (slot_last)  phase_d = PH_WINDOW;
      PH_WINDOW: if (win_expire) phase_d = PH_READ;
      PH_READ:   if (slot_last)  phase_d = PH_EXIT;
      PH_EXIT:   if (slot_last)  phase_d = PH_DONE;
      default:                   phase_d = PH_IDLE;
    endcase
  end

  assign restart = (phase_d != phase_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      result  <= '0;
    end else begin
      phase_q <= phase_d;
      if (phase_q == PH_EXIT && phase_d == PH_DONE) result <= captured;
    end
  end

  fds_slot_pacer #(.IDX_W(IDX_W)) i_pacer (
    .clk(clk), .rst(rst), .restart(restart), .run(pacer_run),
    .half(half), .idx(idx), .slot_end(slot_end)
  );

  fds_window_timer #(.DET_CYCLES(DET_CYCLES)) i_timer (
    .clk(clk), .rst(rst), .active(win_active), .expire(win_expire)
  );

  fds_readback #(.BITS(BITS)) i_readback (
    .clk(clk), .rst(rst), .take(take), .bit_in(drv_sdo), .word(captured)
  );

  // pin decode from registered state: levels move only when half returns to 0
  always_comb begin
    drv_clk  = half && phase_pulses(phase_q);
    drv_sdi  = (phase_q == PH_LOAD);
    drv_le   = 1'b0;
    drv_oe_n = 1'b1;
    case (phase_q)
      PH_ENTRY: begin
        drv_oe_n = key_oe_n(int'(idx));
        drv_le   = key_le_entry(int'(idx));
      end
      PH_EXIT:   drv_oe_n = key_oe_n(int'(idx));
      PH_LATCH:  drv_le   = 1'b1;
      PH_WINDOW: drv_oe_n = 1'b0;
      default: ;
    endcase
  end

  assign done = (phase_q == PH_DONE);

  a_r2_steady_at_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_clk) |-> ($stable(drv_sdi) && $stable(drv_le) && $stable(drv_oe_n)));

  a_r4_ones_loaded: assert property (@(posedge clk) disable iff (rst)
    (drv_clk && phase_q == PH_LOAD) |-> (drv_sdi && drv_oe_n && !drv_le));

  a_r5_latch_no_clock: assert property (@(posedge clk) disable iff (rst)
    (drv_le && phase_q != PH_ENTRY) |-> !drv_clk);

  a_r6_enable_low_place: assert property (@(posedge clk) disable iff (rst)
    !drv_oe_n |-> (phase_q == PH_WINDOW || phase_q == PH_ENTRY || phase_q == PH_EXIT));

  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_result_on_done: assert property (@(posedge clk) disable iff (rst)
    $changed(result) |-> done);

  a_r10_no_restart_from_done: assert property (@(posedge clk) disable iff (rst)
    done |=> (phase_q == PH_IDLE));
endmodule

// File: tb/test_fault_scan_sequencer.sv
module test_fault_scan_sequencer;
  localparam int BITS = 16;
  localparam int DET  = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic drv_sdo, drv_clk, drv_sdi, drv_le, drv_oe_n, done;
  logic [BITS-1:0] result;

  int n_total = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  fault_scan_sequencer #(.BITS(BITS), .DET_CYCLES(DET)) i_fault_scan_sequencer (
    .clk(clk), .rst(rst), .start(start), .drv_sdo(drv_sdo),
    .drv_clk(drv_clk), .drv_sdi(drv_sdi), .drv_le(drv_le), .drv_oe_n(drv_oe_n),
    .result(result), .done(done)
  );

  // behavioural driver model, evaluated away from the active edge
  logic [15:0] m_sr, m_latch, fault_word;
  logic [4:0]  m_oe_h, m_le_h;
  logic        m_detect, p_clk, p_oe, p_sdi, p_le;
  int          m_low, m_win_len, m_entries, m_exits, m_edge_bad, m_le_low;

  assign drv_sdo = m_sr[15];

  always @(negedge clk) begin
    if (rst) begin
      m_sr = '0; m_latch = '0; m_oe_h = '1; m_le_h = '0; m_detect = 1'b0;
      p_clk = 1'b0; p_oe = 1'b1; p_sdi = 1'b0; p_le = 1'b0;
      m_low = 0; m_win_len = 0; m_entries = 0; m_exits = 0; m_edge_bad = 0; m_le_low = 0;
    end else begin
      if (drv_clk && !p_clk) begin
        if (drv_sdi !== p_sdi || drv_le !== p_le || drv_oe_n !== p_oe) m_edge_bad++;
        m_sr   = {m_sr[14:0], drv_sdi};
        m_oe_h = {m_oe_h[3:0], drv_oe_n};
        m_le_h = {m_le_h[3:0], drv_le};
        if (m_oe_h == 5'b10111 && m_le_h == 5'b00010) begin m_detect = 1'b1; m_entries++; end
        else if (m_oe_h == 5'b10111 && m_le_h == 5'b00000) begin m_detect = 1'b0; m_exits++; end
      end
      if (drv_clk && !p_clk && drv_le) m_latch = m_sr;
      if (drv_le && !drv_clk) begin m_latch = m_sr; m_le_low++; end
      if (!drv_oe_n) m_low = p_oe ? 1 : m_low + 1;
      if (drv_oe_n && !p_oe) begin
        if (m_low > 2) m_win_len = m_low;
        if (m_detect && m_latch == 16'hFFFF && m_low >= DET) m_sr = fault_word;
        else m_sr = ~fault_word;
      end
      p_clk = drv_clk; p_oe = drv_oe_n; p_sdi = drv_sdi; p_le = drv_le;
    end
  end

  function automatic int expected_len();
    // key pulses, load pulses, latch strobe, read pulses, closing key, window
    return 10 + 4 * BITS + 2 + 10 + DET;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  endtask

  task automatic run_pass(input logic [15:0] fw, input int busy_at);
    int lat, e0, x0, eb0, le0;
    logic [15:0] res;
    fault_word = fw;
    e0 = m_entries; x0 = m_exits; eb0 = m_edge_bad; le0 = m_le_low;
    @(negedge clk) start = 1'b1;
    @(posedge clk);
    @(negedge clk) start = 1'b0;
    lat = 0;
    while (1) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      start = (lat == busy_at);
      if (done) break;
      if (lat > 5000) begin
        n_total++; n_bad++;
        $display("FAIL watchdog R9 actual=%0d expected=%0d", lat, expected_len());
        finish_run();
      end
    end
    start = 1'b0;
    res = result;
    chk("R7 fault word", res, fw);
    chk("R9 latency", lat, expected_len());
    chk("R3 entry key seen once", m_entries - e0, 1);
    chk("R8 exit key seen once", m_exits - x0, 1);
    chk("R8 back in normal mode", m_detect, 0);
    chk("R2 no move at rising edge", m_edge_bad - eb0, 0);
    chk("R4 latch all ones", m_latch, 16'hFFFF);
    chk("R5 strobe cycles with clock low", m_le_low - le0, 3);
    chk("R6 window length", m_win_len, DET);
    @(negedge clk);
    chk("R9 done one cycle", done, 0);
    chk("R9 result held", result, res);
  endtask

  task automatic quiet_check(input int cycles);
    int extra_done = 0, extra_clk = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (done) extra_done++;
      if (drv_clk) extra_clk++;
    end
    chk("R10 no second done", extra_done, 0);
    chk("R10 no restarted clocking", extra_clk, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 reset clk", drv_clk, 0);
    chk("R1 reset oe_n", drv_oe_n, 1);
    chk("R1 reset le", drv_le, 0);
    chk("R1 reset done", done, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 idle sdi", drv_sdi, 0);
    chk("R1 idle result", result, 0);
    chk("R1 idle clk", drv_clk, 0);

    run_pass(16'h0000, -1);
    run_pass(16'hFFFF, -1);
    run_pass(16'h8000, -1);
    run_pass(16'h0001, -1);
    run_pass(16'hA5A5, -1);
    run_pass(16'h5A5A, -1);
    for (int k = 0; k < 6; k++) run_pass(16'($urandom), -1);

    run_pass(16'h1234, 30);
    quiet_check(300);
    run_pass(16'hC003, expected_len() - 1);
    quiet_check(300);

    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_total++; n_bad++;
    $display("FAIL watchdog global actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end
endmodule